// File: doc/BRIEF.md
# Privileged Error Status Register Bank

This block collects error events from two groups of error channels into sticky status flags and lets software inspect and clear them through a small register port. Every access carries a privilege indicator. Anyone may read, but only privileged accesses may clear anything. Each group also drives a pending output. A group's pending output is high when any of its flags is set together with that channel's interrupt enable.

Group 1 is the long-lived group. Its flags survive a warm reset and are cleared only by power-on reset or by a privileged write-one. Group 2 flags return to zero on either reset. A group 2 flag is also cleared by a privileged read of the vector register when that read returns the flag's channel. A shadow copy of group 2 records every group 2 event. The shadow is read-only and only power-on reset clears it.

The register port has no wait states. A read issued in one cycle returns its data, with `rd_valid`, in the next cycle. Writes give no response. While warm reset is high, requests are dropped.

Top module: `err_status_bank`

## Requirements
- R1: An error pulse on a channel sets that channel's group flag at the next clock edge whether its interrupt enable is set or not. A group 2 pulse also sets the same bit of the shadow register.
- R2: A read of offset 0x18 (group 1 flags), 0x1C (group 2 flags) or 0x20 (group 2 shadow) returns the value the register held in the request cycle, with `rd_valid` high one cycle after the request, in both user and privileged mode. In every other cycle `rd_valid` and `rd_data` are 0, and reads of unmapped offsets return 0.
- R3: A privileged write to 0x18 or 0x1C clears each flag whose write-data bit is 1 and leaves flags whose bit is 0 unchanged.
- R4: A write with `req_priv` low changes no state and produces no response.
- R5: While `warm_rst` is high at a clock edge, group 2 flags clear, group 1 flags and the shadow keep their value (new events still set them), and bus requests are dropped.
- R6: Power-on reset (`por_n` low) clears group 1, group 2 and the shadow.
- R7: A read of the vector register at 0x24 returns one plus the lowest-numbered group 2 channel whose flag and enable are both set, or 0 when there is none.
- R8: A privileged read of 0x24 that returns a nonzero vector clears that group 2 flag. It clears neither group 1 nor the shadow. A user-mode read of 0x24 returns the vector and clears nothing.
- R9: The shadow register is unaffected by writes to any offset, including write-one clears of group 2 and writes to 0x20.
- R10: When an error pulse and a clear hit the same flag in the same cycle, the flag ends up set.
- R11: `g1_pending` equals the OR over group 1 of flag AND enable. `g2_pending` is the same for group 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| g1_err | input | CH | Group 1 error pulses, one per channel |
| g2_err | input | CH | Group 2 error pulses, one per channel |
| g1_irq_en | input | CH | Group 1 interrupt enables |
| g2_irq_en | input | CH | Group 2 interrupt enables |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged access |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | CH | Write data, 1 bits select flags to clear |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | CH | Read data, 0 when not valid |
| g1_pending | output | 1 | Some enabled group 1 flag is set |
| g2_pending | output | 1 | Some enabled group 2 flag is set |

## Verification
The hardest situations to reach from the ports are the collisions. One is a privileged vector read in the same cycle as a fresh event on the channel that read is clearing. Another is a warm reset that arrives while group 1 and the shadow hold flags and events are still arriving. The stimulus combines sparse random error pulses, random enables and random privileged and user accesses across all offsets, with a rare random warm reset. This keeps several flags live at once, so collisions occur often. Directed steps then force each collision exactly once, on known channels, and confirm the survivors by reading the registers back.

// File: rtl/esb_pkg.sv
package esb_pkg;
    localparam int unsigned OFS_G1  = 32'h18;
    localparam int unsigned OFS_G2  = 32'h1C;
    localparam int unsigned OFS_SHD = 32'h20;
    localparam int unsigned OFS_VEC = 32'h24;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_G1,
        SEL_G2,
        SEL_SHD,
        SEL_VEC
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        logic     priv;
        reg_sel_e sel;
    } bus_op_t;
endpackage

// File: rtl/esb_decode.sv
module esb_decode
    import esb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              warm_rst,
    output bus_op_t           op_o
);
    reg_sel_e sel;

    always_comb begin
        if (req_addr == ADDR_W'(OFS_G1))       sel = SEL_G1;
        else if (req_addr == ADDR_W'(OFS_G2))  sel = SEL_G2;
        else if (req_addr == ADDR_W'(OFS_SHD)) sel = SEL_SHD;
        else if (req_addr == ADDR_W'(OFS_VEC)) sel = SEL_VEC;
        else                                   sel = SEL_NONE;
    end

    always_comb begin
        op_o.rd   = req_valid && !req_write && !warm_rst;
        op_o.wr   = req_valid &&  req_write && !warm_rst;
        op_o.priv = req_priv;
        op_o.sel  = sel;
    end
endmodule

// File: rtl/esb_flag_bank.sv
module esb_flag_bank #(
    parameter int unsigned N            = 32,
    parameter bit          KEEP_ON_WARM = 1'b0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         warm_rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic wipe;
    assign wipe = warm_rst && (KEEP_ON_WARM == 1'b0);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            flags_o <= '0;
        else if (wipe)
            flags_o <= '0;
        else
            flags_o <= (flags_o & ~clr_i) | set_i;
    end

    // R10: an event always lands, even against a simultaneous clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!por_n)
        !wipe |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R3: a flag only falls where a clear was requested
    a_r3_fall_needs_clear: assert property (@(posedge clk) disable iff (!por_n)
        !wipe |=> ((($past(flags_o) & ~flags_o) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/esb_vec_find.sv
module esb_vec_find #(
    parameter int unsigned N  = 32,
    parameter int unsigned VW = $clog2(N + 1)
) (
    input  logic [N-1:0]  pend_i,
    output logic [VW-1:0] vec_o
);
    always_comb begin
        vec_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) vec_o = VW'(i + 1);
        end
    end
endmodule

// File: rtl/err_status_bank.sv
module err_status_bank
    import esb_pkg::*;
#(
    parameter int unsigned CH     = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst,
    input  logic [CH-1:0]     g1_err,
    input  logic [CH-1:0]     g2_err,
    input  logic [CH-1:0]     g1_irq_en,
    input  logic [CH-1:0]     g2_irq_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CH-1:0]     req_wdata,
    output logic              rd_valid,
    output logic [CH-1:0]     rd_data,
    output logic              g1_pending,
    output logic              g2_pending
);
    localparam int unsigned VW = $clog2(CH + 1);

    bus_op_t       op;
    logic [CH-1:0] g1_flags, g2_flags, shd_flags;
    logic [CH-1:0] g1_clr, g2_clr, vec_mask, rd_mux;
    logic [VW-1:0] vec;
    logic          priv_wr, vec_take;

    esb_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_priv  (req_priv),
        .req_addr  (req_addr),
        .warm_rst  (warm_rst),
        .op_o      (op)
    );

    esb_vec_find #(.N(CH), .VW(VW)) u_vec (
        .pend_i (g2_flags & g2_irq_en),
        .vec_o  (vec)
    );

    for (genvar i = 0; i < CH; i++) begin : g_vmask
        assign vec_mask[i] = (vec == VW'(i + 1));
    end

    assign priv_wr  = op.wr && op.priv;
    assign vec_take = op.rd && op.priv && (op.sel == SEL_VEC);
    assign g1_clr   = (priv_wr && op.sel == SEL_G1) ? req_wdata : '0;
    assign g2_clr   = ((priv_wr && op.sel == SEL_G2) ? req_wdata : '0)
                    | (vec_take ? vec_mask : '0);

    esb_flag_bank #(.N(CH), .KEEP_ON_WARM(1'b1)) u_g1 (
        .clk (clk), .por_n (por_n), .warm_rst (warm_rst),
        .set_i (g1_err), .clr_i (g1_clr), .flags_o (g1_flags)
    );

    esb_flag_bank #(.N(CH), .KEEP_ON_WARM(1'b0)) u_g2 (
        .clk (clk), .por_n (por_n), .warm_rst (warm_rst),
        .set_i (g2_err), .clr_i (g2_clr), .flags_o (g2_flags)
    );

    esb_flag_bank #(.N(CH), .KEEP_ON_WARM(1'b1)) u_shd (
        .clk (clk), .por_n (por_n), .warm_rst (warm_rst),
        .set_i (g2_err), .clr_i ('0), .flags_o (shd_flags)
    );

    always_comb begin
        unique case (op.sel)
            SEL_G1:  rd_mux = g1_flags;
            SEL_G2:  rd_mux = g2_flags;
            SEL_SHD: rd_mux = shd_flags;
            SEL_VEC: rd_mux = CH'(vec);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= op.rd;
            rd_data  <= op.rd ? rd_mux : '0;
        end
    end

    assign g1_pending = |(g1_flags & g1_irq_en);
    assign g2_pending = |(g2_flags & g2_irq_en);

    // R9: every live group 2 flag is mirrored in the shadow
    a_r9_shadow_covers_g2: assert property (@(posedge clk) disable iff (!por_n)
        (g2_flags & ~shd_flags) == '0);

    // R4: a user-mode write never drops a flag
    a_r4_user_write_keeps: assert property (@(posedge clk) disable iff (!por_n)
        (req_valid && req_write && !req_priv && !warm_rst) |=>
        ((($past(g1_flags) & ~g1_flags) | ($past(g2_flags) & ~g2_flags)) == '0));

    // R2: every accepted read is answered next cycle
    a_r2_read_answers: assert property (@(posedge clk) disable iff (!por_n)
        (req_valid && !req_write && !warm_rst) |=> rd_valid);

    // R5: group 1 and shadow ride through warm reset
    a_r5_warm_keeps: assert property (@(posedge clk) disable iff (!por_n)
        warm_rst |=> ((($past(g1_flags) & ~g1_flags) | ($past(shd_flags) & ~shd_flags)) == '0));

    // R8: a privileged vector read removes the reported flag
    a_r8_vec_read_clears: assert property (@(posedge clk) disable iff (!por_n)
        (vec_take && vec != '0 && (g2_err & vec_mask) == '0) |=>
        ((g2_flags & $past(vec_mask)) == '0));
endmodule

// File: tb/err_status_bank_bench.sv
module err_status_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CH = 32;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic warm = 1'b0;
    logic [CH-1:0] e1 = '0, e2 = '0, en1 = '0, en2 = '0;
    logic rv = 1'b0, rw = 1'b0, rp = 1'b0;
    logic [7:0] ra = '0;
    logic [CH-1:0] rwd = '0;
    logic rd_valid, g1_pending, g2_pending;
    logic [CH-1:0] rd_data;

    logic [CH-1:0] m1 = '0, m2 = '0, msh = '0;
    int n_chk = 0, n_bad = 0, n_cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    err_status_bank u_err_status_bank (
        .clk (clk), .por_n (por_n), .warm_rst (warm),
        .g1_err (e1), .g2_err (e2), .g1_irq_en (en1), .g2_irq_en (en2),
        .req_valid (rv), .req_write (rw), .req_priv (rp),
        .req_addr (ra), .req_wdata (rwd),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .g1_pending (g1_pending), .g2_pending (g2_pending)
    );

    function automatic logic [CH-1:0] ref_vec(logic [CH-1:0] f, logic [CH-1:0] en);
        logic [CH-1:0] p = f & en;
        for (int i = 0; i < CH; i++) if (p[i]) return CH'(i + 1);
        return '0;
    endfunction

    function automatic logic [CH-1:0] ref_read(logic [7:0] a);
        case (a)
            8'h18:   return m1;
            8'h1C:   return m2;
            8'h20:   return msh;
            8'h24:   return ref_vec(m2, en2);
            default: return '0;
        endcase
    endfunction

    task automatic chk(string tag, logic [CH-1:0] act, logic [CH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // one clock: inputs already set; model advanced; outputs checked at negedge
    task automatic cyc(string tag);
        logic exp_v;
        logic [CH-1:0] exp_d, c1, c2, v;
        exp_v = rv && !rw && !warm;
        exp_d = exp_v ? ref_read(ra) : '0;
        if (warm) begin
            m1 = m1 | e1;
            m2 = '0;
        end else begin
            c1 = '0; c2 = '0;
            if (rv && rw && rp && ra == 8'h18) c1 = rwd;
            if (rv && rw && rp && ra == 8'h1C) c2 = rwd;
            if (rv && !rw && rp && ra == 8'h24) begin
                v = ref_vec(m2, en2);
                if (v != 0) c2 = c2 | (CH'(1) << (v - 1));
            end
            m1 = (m1 & ~c1) | e1;
            m2 = (m2 & ~c2) | e2;
        end
        msh = msh | e2;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " valid"}, CH'(rd_valid), CH'(exp_v));
        chk({tag, " data"}, rd_data, exp_d);
        chk("R11 g1", CH'(g1_pending), CH'(|(m1 & en1)));
        chk("R11 g2", CH'(g2_pending), CH'(|(m2 & en2)));
        rv = 1'b0; rw = 1'b0; e1 = '0; e2 = '0; warm = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic p, string tag);
        rv = 1'b1; rw = 1'b0; rp = p; ra = a;
        cyc(tag);
    endtask

    task automatic wr(logic [7:0] a, logic [CH-1:0] d, logic p, string tag);
        rv = 1'b1; rw = 1'b1; rp = p; ra = a; rwd = d;
        cyc(tag);
    endtask

    task automatic power_on();
        @(negedge clk);
        por_n = 1'b0;
        m1 = '0; m2 = '0; msh = '0;
        @(negedge clk);
        @(negedge clk);
        por_n = 1'b1;
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", n_cyc);
            finish_run();
        end
    end

    initial begin
        logic [7:0] addrs [5];
        addrs = '{8'h18, 8'h1C, 8'h20, 8'h24, 8'h10};
        void'($urandom(32'd4711));
        power_on();

        // R6: all registers clear after power-on
        rd(8'h18, 1, "R6"); rd(8'h1C, 0, "R6"); rd(8'h20, 1, "R6"); rd(8'h24, 0, "R6");

        // R1: events set flags with enables off
        e1 = 32'h20; e2 = 32'h200; cyc("R1");
        rd(8'h18, 0, "R1"); rd(8'h1C, 0, "R1"); rd(8'h20, 1, "R1");
        en1 = 32'h20; cyc("R11");

        // R4: user write is ignored
        wr(8'h18, '1, 0, "R4"); rd(8'h18, 1, "R4");
        wr(8'h1C, '1, 0, "R4"); rd(8'h1C, 1, "R4");

        // R3: selective clear
        e1 = 32'h80; cyc("R3");
        wr(8'h18, 32'h80, 1, "R3"); rd(8'h18, 1, "R3");

        // R10: set beats a clear in the same cycle
        e1 = 32'h20; rv = 1; rw = 1; rp = 1; ra = 8'h18; rwd = 32'h20; cyc("R10");
        rd(8'h18, 0, "R10");

        // R7 / R8: vector reads
        e2 = 32'h8; en2 = 32'h208; cyc("R7");
        rd(8'h24, 1, "R7"); rd(8'h1C, 1, "R8");
        rd(8'h24, 0, "R8"); rd(8'h24, 0, "R8"); rd(8'h1C, 0, "R8");
        rd(8'h20, 0, "R8"); rd(8'h18, 0, "R8");
        e2 = 32'h200; rv = 1; rw = 0; rp = 1; ra = 8'h24; cyc("R10"); rd(8'h1C, 1, "R10");

        // R9: shadow untouched by writes
        wr(8'h1C, '1, 1, "R9"); rd(8'h20, 1, "R9"); rd(8'h24, 1, "R7");
        wr(8'h20, '1, 1, "R9"); rd(8'h20, 1, "R9");

        // R5: warm reset
        e2 = 32'h4; cyc("R5");
        warm = 1; e1 = 32'h1000; rv = 1; rw = 0; rp = 1; ra = 8'h18; cyc("R5");
        rd(8'h18, 1, "R5"); rd(8'h1C, 1, "R5"); rd(8'h20, 1, "R5");

        // random mix
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] a;
            e1 = $urandom & $urandom & $urandom;
            e2 = $urandom & $urandom & $urandom;
            if ($urandom_range(0, 15) == 0) en1 = $urandom;
            if ($urandom_range(0, 15) == 0) en2 = $urandom;
            a  = addrs[$urandom_range(0, 4)];
            rv = ($urandom_range(0, 9) < 6);
            rw = $urandom_range(0, 1);
            rp = ($urandom_range(0, 9) < 7);
            ra = a;
            rwd = $urandom_range(0, 1) ? $urandom : ($urandom & $urandom);
            warm = ($urandom_range(0, 99) == 0);
            cyc(a == 8'h24 ? "R7" : "R2");
        end

        // R6: power-on reset mid-run
        e1 = '1; e2 = '1; cyc("R1");
        power_on();
        rd(8'h18, 1, "R6"); rd(8'h1C, 1, "R6"); rd(8'h20, 1, "R6");

        finish_run();
    end
endmodule